// File: doc/BRIEF.md
# Masked Byte Insert, Compare and Store Unit

The unit moves or compares selected bytes of a 32-bit register against a run of consecutive memory bytes. A 4-bit mask picks which register bytes take part. The selected bytes need not be adjacent in the register, but they always map onto adjacent memory bytes. The memory bytes start at the operand address and are taken in left-to-right register order.

Three operations are available. Insert reads memory into the selected register bytes. Compare checks the selected register bytes against memory as unsigned values. Store writes the selected register bytes to memory. Every operation returns a 2-bit condition code that is derived from the bytes it handled.

A caller pulses `start_i` with the operation, mask, address and register value. The unit then drives a byte-wide memory port with a request/ready handshake, one byte per accepted transfer. When it finishes, it presents the resulting register and condition code together with a one-cycle `done_o` pulse.

Top module: `mask_byte_xfer`

## Requirements
- R1: Insert (op code 00) fills register byte i from the left, which is bits [31-8i:24-8i] and selected by mask bit 3-i, from consecutive memory bytes taken in left-to-right order. Bytes whose mask bit is clear keep the value from `reg_i`.
- R2: An operation makes exactly one memory transfer per set mask bit. Compare is the exception: it stops after the first unequal byte. The addresses of the transfers are `addr_i`, `addr_i`+1, and so on in order.
- R3: Store (op code 10) writes the selected register bytes to consecutive addresses and leaves the bytes after them untouched. `mem_we_o` is never high for insert or compare.
- R4: Compare uses op code 01, and code 11 behaves the same way. It compares selected bytes as unsigned values, leftmost first, and stops at the first unequal byte. The condition code is 0 when all bytes are equal, 1 when the register byte is lower and 2 when it is higher. `result_o` equals `reg_i`, and memory is not written.
- R5: After insert or store, the condition code is computed from the transferred bytes. It is 0 when all of them are zero. It is 1 when the first transferred byte has its top bit set. Otherwise it is 2. The value 3 never appears.
- R6: A zero mask makes no memory request. `done_o` rises in the cycle after the start, with condition code 0 and `result_o` equal to `reg_i`.
- R7: A pending request keeps `mem_req_o`, `mem_addr_o`, `mem_we_o` and `mem_wdata_o` stable until `mem_ready_i` is high.
- R8: `done_o` is a single-cycle pulse per operation, asserted the cycle after the last transfer with `busy_o` low. `result_o` and `cc_o` change only when `done_o` is asserted.
- R9: A start pulse that arrives while `busy_o` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| op_i | input | 2 | 00 insert, 01/11 compare, 10 store |
| mask_i | input | 4 | Byte select, MSB is leftmost register byte |
| addr_i | input | 32 | First memory byte address |
| reg_i | input | 32 | Register operand |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 8 | Store data byte |
| mem_ready_i | input | 1 | Memory ready, transfer on req and ready |
| mem_rdata_i | input | 8 | Read data, valid with ready |
| result_o | output | 32 | Resulting register value |
| cc_o | output | 2 | Condition code |
| done_o | output | 1 | Completion pulse |
| busy_o | output | 1 | Operation in progress |

## Verification
The assertions assume three things about the memory side. `mem_ready_i` may be low for any number of cycles. Read data is valid in the same cycle as ready. The environment never needs a start pulse to be honoured while the unit is busy. The bench's memory model answers combinationally and, when told to, drops ready on alternate cycles, which exercises the hold rule. Start pulses are issued from idle, except for one deliberate pulse during a busy operation, which R9 says must be ignored.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    MBX_INS  = 2'b00,
    MBX_CMP  = 2'b01,
    MBX_STO  = 2'b10,
    MBX_CMPX = 2'b11
  } mbx_op_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } mbx_state_e;
endpackage

// File: rtl/mbx_lead_pick.sv
module mbx_lead_pick #(
  parameter int NB = 4,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic [NB-1:0] mask_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  // leftmost lane wins: mask bit NB-1 is lane 0
  always_comb begin
    idx_o = '0;
    for (int k = NB - 1; k >= 0; k--) begin
      if (mask_i[NB-1-k]) idx_o = IW'(k);
    end
  end
  assign any_o = |mask_i;
endmodule

// File: rtl/mbx_cc_track.sv
module mbx_cc_track #(
  parameter int BW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          take_i,
  input  logic          cmp_i,
  input  logic [BW-1:0] data_i,
  input  logic [BW-1:0] ref_i,
  output logic [1:0]    cc_o,
  output logic          stop_o
);
  logic nz_q, seen_q, lead_q;
  logic nz_n, lead_n, eq, lt;

  assign eq     = (ref_i == data_i);
  assign lt     = (ref_i < data_i);
  assign stop_o = take_i & cmp_i & ~eq;
  assign nz_n   = nz_q | (take_i & (|data_i));
  assign lead_n = seen_q ? lead_q : data_i[BW-1];

  always_comb begin
    if (cmp_i)     cc_o = stop_o ? (lt ? 2'd1 : 2'd2) : 2'd0;
    else if (nz_n) cc_o = lead_n ? 2'd1 : 2'd2;
    else           cc_o = 2'd0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nz_q   <= 1'b0;
      seen_q <= 1'b0;
      lead_q <= 1'b0;
    end else if (clear_i) begin
      nz_q   <= 1'b0;
      seen_q <= 1'b0;
      lead_q <= 1'b0;
    end else if (take_i) begin
      nz_q   <= nz_n;
      seen_q <= 1'b1;
      lead_q <= lead_n;
    end
  end
endmodule

// File: rtl/mask_byte_xfer.sv
module mask_byte_xfer
  import mbx_pkg::*;
#(
  parameter int NB = 4,
  parameter int BW = 8,
  parameter int AW = 32,
  localparam int RW = NB * BW,
  localparam int IW = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [1:0]    op_i,
  input  logic [NB-1:0] mask_i,
  input  logic [AW-1:0] addr_i,
  input  logic [RW-1:0] reg_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [BW-1:0] mem_wdata_o,
  input  logic          mem_ready_i,
  input  logic [BW-1:0] mem_rdata_i,
  output logic [RW-1:0] result_o,
  output logic [1:0]    cc_o,
  output logic          done_o,
  output logic          busy_o
);
  mbx_state_e    state_q;
  logic [1:0]    op_q;
  logic [NB-1:0] mask_q, mask_after, sel_bit;
  logic [AW-1:0] addr_q;
  logic [RW-1:0] work_q, work_nx, result_q;
  logic [1:0]    cc_q, cc_nx;
  logic          done_q;

  logic [IW-1:0] cur_idx;
  logic          cur_any;
  logic [NB-1:0] lane_hit;
  logic [BW-1:0] cur_byte, cc_data;
  logic          run, xfer, accept, last, stop;
  logic          is_ins, is_sto, is_cmp;

  assign run    = (state_q == ST_RUN);
  assign xfer   = run & mem_ready_i;
  assign accept = start_i & ~run;
  assign is_ins = (op_q == MBX_INS);
  assign is_sto = (op_q == MBX_STO);
  assign is_cmp = op_q[0];

  mbx_lead_pick #(.NB(NB)) u_pick (
    .mask_i (mask_q),
    .idx_o  (cur_idx),
    .any_o  (cur_any)
  );

  for (genvar k = 0; k < NB; k++) begin : g_lane
    localparam int LO = BW * (NB - 1 - k);
    assign lane_hit[k]       = cur_any && (cur_idx == IW'(k));
    assign sel_bit[NB-1-k]   = lane_hit[k];
    assign work_nx[LO +: BW] = (xfer && is_ins && lane_hit[k]) ? mem_rdata_i
                                                               : work_q[LO +: BW];
  end

  always_comb begin
    cur_byte = '0;
    for (int k = 0; k < NB; k++) begin
      if (lane_hit[k]) cur_byte = work_q[BW*(NB-1-k) +: BW];
    end
  end

  assign mask_after = mask_q & ~sel_bit;
  assign cc_data    = is_sto ? cur_byte : mem_rdata_i;
  assign last       = xfer & ((mask_after == '0) | stop);

  mbx_cc_track #(.BW(BW)) u_cc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (accept),
    .take_i  (xfer),
    .cmp_i   (is_cmp),
    .data_i  (cc_data),
    .ref_i   (cur_byte),
    .cc_o    (cc_nx),
    .stop_o  (stop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      op_q     <= 2'b00;
      mask_q   <= '0;
      addr_q   <= '0;
      work_q   <= '0;
      result_q <= '0;
      cc_q     <= 2'd0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        if (mask_i == '0) begin
          done_q   <= 1'b1;
          result_q <= reg_i;
          cc_q     <= 2'd0;
        end else begin
          state_q <= ST_RUN;
          op_q    <= op_i;
          mask_q  <= mask_i;
          addr_q  <= addr_i;
          work_q  <= reg_i;
        end
      end else if (xfer) begin
        work_q <= work_nx;
        mask_q <= mask_after;
        addr_q <= addr_q + 1'b1;
        if (last) begin
          state_q  <= ST_IDLE;
          done_q   <= 1'b1;
          result_q <= work_nx;
          cc_q     <= cc_nx;
        end
      end
    end
  end

  assign mem_req_o   = run;
  assign mem_we_o    = run & is_sto;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = cur_byte;
  assign result_o    = result_q;
  assign cc_o        = cc_q;
  assign done_o      = done_q;
  assign busy_o      = run;
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk #(
  parameter int NB = 4,
  parameter int BW = 8,
  parameter int AW = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [NB-1:0] mask_i,
  input logic [1:0]    op_q,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic          mem_ready_i,
  input logic [AW-1:0] mem_addr_o,
  input logic [BW-1:0] mem_wdata_o,
  input logic [NB*BW-1:0] result_o,
  input logic [1:0]    cc_o,
  input logic          done_o,
  input logic          busy_o
);
  // R2
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ready_i) |=> (!mem_req_o || mem_addr_o == $past(mem_addr_o) + 1'b1));

  // R3
  write_only_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> (op_q == 2'b10));

  // R5
  cc_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cc_o != 2'b11);

  // R6
  zero_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && mask_i == '0) |=> (done_o && !mem_req_o));

  // R7
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o)
      && $stable(mem_we_o) && $stable(mem_wdata_o)));

  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  // R8
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> ($stable(result_o) && $stable(cc_o)));

  // R2
  req_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> busy_o);
endmodule

bind mask_byte_xfer mbx_chk #(.NB(NB), .BW(BW), .AW(AW)) u_mbx_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .mask_i      (mask_i),
  .op_q        (op_q),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_ready_i (mem_ready_i),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .result_o    (result_o),
  .cc_o        (cc_o),
  .done_o      (done_o),
  .busy_o      (busy_o)
);

// File: tb/mask_byte_xfer_bench.sv
module mask_byte_xfer_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic [3:0]  mask_i = 4'h0;
  logic [31:0] addr_i = '0;
  logic [31:0] reg_i = '0;
  logic        mem_req_o, mem_we_o, done_o, busy_o;
  logic [31:0] mem_addr_o, result_o;
  logic [7:0]  mem_wdata_o, mem_rdata_i;
  logic [1:0]  cc_o;
  logic        mem_ready_i;

  logic [7:0]  mem [0:255];
  logic        stall_en = 1'b0;
  logic        tick = 1'b0;
  logic        pl_en = 1'b0;
  logic [7:0]  pl_addr = '0, pl_data = '0;
  int          acc_n = 0, wr_n = 0, done_n = 0, cyc = 0;
  logic [31:0] acc_log [0:255];
  int          checks = 0, errors = 0;

  always #2 clk_i = ~clk_i;

  mask_byte_xfer u_mask_byte_xfer (
    .clk_i, .rst_ni, .start_i, .op_i, .mask_i, .addr_i, .reg_i,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ready_i, .mem_rdata_i,
    .result_o, .cc_o, .done_o, .busy_o
  );

  assign mem_ready_i = !stall_en || tick;
  assign mem_rdata_i = mem[mem_addr_o[7:0]];

  always @(posedge clk_i) begin
    tick <= ~tick;
    cyc  <= cyc + 1;
    if (done_o) done_n <= done_n + 1;
    if (pl_en) mem[pl_addr] <= pl_data;
    if (mem_req_o && mem_ready_i) begin
      acc_log[acc_n[7:0]] <= mem_addr_o;
      acc_n <= acc_n + 1;
      if (mem_we_o) begin
        mem[mem_addr_o[7:0]] <= mem_wdata_o;
        wr_n <= wr_n + 1;
      end
    end
  end

  initial begin
    wait (cyc > 100000);
    errors = errors + 1;
    $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    pl_en = 1'b1; pl_addr = a; pl_data = d;
    @(negedge clk_i);
    pl_en = 1'b0;
  endtask

  task automatic launch(input logic [1:0] op, input logic [3:0] m,
                        input logic [31:0] a, input logic [31:0] r);
    @(negedge clk_i);
    start_i = 1'b1; op_i = op; mask_i = m; addr_i = a; reg_i = r;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done_o && n < 200) begin
      @(negedge clk_i);
      n++;
    end
    chk(req, {31'd0, done_o}, 32'd1);
  endtask

  // runs one op; checks result, cc, access count, single done pulse
  task automatic do_op(input string req, input logic [1:0] op, input logic [3:0] m,
                       input logic [31:0] a, input logic [31:0] r,
                       input logic [31:0] exp_res, input logic [1:0] exp_cc,
                       input int exp_acc, output int a0);
    int d0;
    a0 = acc_n;
    d0 = done_n;
    launch(op, m, a, r);
    wait_done(req);
    chk(req, result_o, exp_res);
    chk(req, {30'd0, cc_o}, {30'd0, exp_cc});
    repeat (3) @(negedge clk_i);
    chk(req, acc_n - a0, exp_acc);
    chk("R8", done_n - d0, 1);
  endtask

  task automatic t_reset();
    chk("R8", {busy_o, done_o, mem_req_o}, 0);
    chk("R8", result_o, 0);
    chk("R8", {30'd0, cc_o}, 0);
  endtask

  task automatic t_ins_sparse();
    int a0;
    poke(8'h10, 8'h12); poke(8'h11, 8'h34);
    do_op("R1", 2'b00, 4'b1010, 32'h10, 32'hAABBCCDD, 32'h12BB34DD, 2'd2, 2, a0);
    chk("R2", acc_log[a0[7:0]], 32'h10);
    chk("R2", acc_log[a0[7:0]+1], 32'h11);
  endtask

  task automatic t_ins_full();
    int a0;
    poke(8'h20, 8'h80); poke(8'h21, 8'h00); poke(8'h22, 8'h00); poke(8'h23, 8'h01);
    do_op("R5", 2'b00, 4'b1111, 32'h20, 32'h0, 32'h80000001, 2'd1, 4, a0);
  endtask

  task automatic t_ins_low_zero();
    int a0;
    poke(8'h30, 8'h00);
    do_op("R5", 2'b00, 4'b0001, 32'h30, 32'h12345678, 32'h12345600, 2'd0, 1, a0);
  endtask

  task automatic t_zero_mask();
    int a0, w0;
    a0 = acc_n;
    w0 = wr_n;
    launch(2'b00, 4'b0000, 32'h40, 32'hCAFEF00D);
    chk("R6", {31'd0, done_o}, 1);
    chk("R6", result_o, 32'hCAFEF00D);
    chk("R6", {30'd0, cc_o}, 0);
    launch(2'b10, 4'b0000, 32'h40, 32'h11111111);
    chk("R6", {31'd0, done_o}, 1);
    repeat (2) @(negedge clk_i);
    chk("R6", acc_n - a0, 0);
    chk("R6", wr_n - w0, 0);
  endtask

  task automatic t_cmp();
    int a0, w0;
    w0 = wr_n;
    poke(8'h40, 8'hAA); poke(8'h41, 8'hCC);
    do_op("R4", 2'b01, 4'b0110, 32'h40, 32'h11AACC22, 32'h11AACC22, 2'd0, 2, a0);
    poke(8'h50, 8'h20); poke(8'h51, 8'h00);
    do_op("R4", 2'b01, 4'b1100, 32'h50, 32'h10FF0000, 32'h10FF0000, 2'd1, 1, a0);
    poke(8'h58, 8'h20); poke(8'h59, 8'h80);
    do_op("R4", 2'b11, 4'b0011, 32'h58, 32'h00002090, 32'h00002090, 2'd2, 2, a0);
    chk("R3", wr_n - w0, 0);
    chk("R4", {mem[8'h40], mem[8'h41], mem[8'h59]}, 32'h00AACC80);
  endtask

  task automatic t_store();
    int a0, w0;
    poke(8'h60, 8'h55); poke(8'h61, 8'h55); poke(8'h62, 8'h55); poke(8'h63, 8'h55);
    w0 = wr_n;
    do_op("R3", 2'b10, 4'b0111, 32'h60, 32'h99ABCDEF, 32'h99ABCDEF, 2'd1, 3, a0);
    chk("R3", {mem[8'h60], mem[8'h61], mem[8'h62], mem[8'h63]}, 32'hABCDEF55);
    chk("R3", wr_n - w0, 3);
    chk("R2", acc_log[a0[7:0]+2], 32'h62);
  endtask

  task automatic t_stall();
    int a0;
    poke(8'h70, 8'h00); poke(8'h71, 8'h7F);
    stall_en = 1'b1;
    do_op("R7", 2'b00, 4'b1001, 32'h70, 32'hFFFFFFFF, 32'h00FFFF7F, 2'd2, 2, a0);
    chk("R7", acc_log[a0[7:0]+1], 32'h71);
    stall_en = 1'b0;
  endtask

  task automatic t_busy_ignore();
    int a0, w0, d0;
    poke(8'h78, 8'h01); poke(8'h79, 8'h02);
    stall_en = 1'b1;
    a0 = acc_n; w0 = wr_n; d0 = done_n;
    launch(2'b00, 4'b1100, 32'h78, 32'h0);
    chk("R9", {31'd0, busy_o}, 1);
    start_i = 1'b1; op_i = 2'b10; mask_i = 4'b0011; addr_i = 32'h7C; reg_i = 32'hFFFFFFFF;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_done("R9");
    chk("R9", result_o, 32'h01020000);
    repeat (6) @(negedge clk_i);
    chk("R9", done_n - d0, 1);
    chk("R9", wr_n - w0, 0);
    chk("R9", acc_n - a0, 2);
    stall_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_ins_sparse();
    t_ins_full();
    t_ins_low_zero();
    t_zero_mask();
    t_cmp();
    t_store();
    t_stall();
    t_busy_ignore();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule